// File: doc/BRIEF.md
# Flash Program Pulse Sequencer

This block produces the control timing for one programming pulse into a flash array. A one-cycle `start` request begins the pulse. The block samples two values at that moment: the pulse class, which is normal or additional programming, and the count of the current write loop.

The block first raises the watchdog enable. It then sets the program-setup line and waits the setup interval. Next it raises the program line for the pulse width and drops it again. It waits a recovery interval, releases program-setup, and waits a release interval. Finally it drops the watchdog enable and strobes `done` for one cycle.

All intervals are counted in microsecond ticks. The ticks come from an internal free-running divider of the clock. The pulse width depends on the sampled inputs:
- A normal pulse in an early loop uses the short width.
- A normal pulse in a later loop uses the long width.
- An additional-programming pulse uses a very short width, whatever the loop count.

The surrounding controller handles data transfer and verification. It issues one request for each pulse and waits for `done`. A synchronous `abort` input drops every output at once and returns the block to idle. The block has no data stream, so all pins are plain control and status signals.

Top module: `flash_pulse_seq`

## Requirements
- R1: After reset, `wdt_en`, `psu`, `prog` and `done` are all low.
- R2: `start` is sampled while idle. `wdt_en` rises on the clock edge that samples it. `psu` rises exactly one cycle after `wdt_en`, and `prog` rises later. The outputs fall in the order `prog`, then `psu`, then `wdt_en`.
- R3: `prog` is never high unless `psu` is high.
- R4: `psu` falls only after `prog` has been low for the recovery interval of `T_HOLD_P_US` ticks.
- R5: A normal pulse (`extra_pulse`=0) with `loop_cnt` of `SHORT_PASSES` (default 6) or less holds `prog` high for `W_SHORT_US` ticks. A `loop_cnt` of 0 also gets this width.
- R6: A normal pulse with `loop_cnt` above `SHORT_PASSES` holds `prog` high for `W_LONG_US` ticks.
- R7: An additional-programming pulse (`extra_pulse`=1) holds `prog` high for `W_EXTRA_US` ticks, whatever `loop_cnt` is.
- R8: `psu` is high for `T_SETUP_US` ticks before `prog` rises. `wdt_en` stays high for `T_HOLD_SETUP_US` ticks after `psu` falls.
- R9: `done` is high for exactly one cycle. That cycle is the first cycle in which `wdt_en` is low again.
- R10: A `start` that arrives while a pulse is in progress is ignored. It does not restart or extend the pulse, and it does not add a second `done`.
- R11: When `abort` is sampled high, all outputs are low on the next cycle and no `done` follows. When `start` and `abort` are high together in idle, nothing starts.
- R12: `extra_pulse` and `loop_cnt` are sampled only with an accepted `start`. Changing them during a pulse has no effect on its width.
- Interval timing: a wait of N ticks lasts between (N-1)·`CLK_PER_US`+1 and N·`CLK_PER_US` clock cycles, because the tick divider runs freely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one programming pulse. Honoured only while idle |
| extra_pulse | input | 1 | Pulse class: 0 is normal, 1 is additional programming |
| loop_cnt | input | LOOP_W | Current write-loop count; selects the short or long width |
| abort | input | 1 | Synchronous abort. All outputs go low and the block returns to idle |
| wdt_en | output | 1 | Watchdog enable, high for the whole sequence |
| psu | output | 1 | Program-setup control |
| prog | output | 1 | Program pulse control |
| done | output | 1 | One-cycle strobe when the sequence has completed |

## Verification
The hardest cases to reach from the ports are an abort or a second `start` that lands in the middle of a pulse. The stimulus first waits until `prog` or `psu` is observed high, and only then drives `abort` or `start`. Because the tick divider phase is free, every interval is checked against a window of cycles rather than an exact count. The width boundaries are covered at loop counts 6/7 and 1000, and with additional programming at both a low and a high loop count. The sampling rule (R12) is tested by changing the class and loop inputs right after the start edge.

// File: rtl/fps_pkg.sv
package fps_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_SETUP,
    ST_PULSE,
    ST_RECOVER,
    ST_RELEASE
  } seq_state_t;

  typedef enum logic {
    PC_NORMAL = 1'b0,
    PC_EXTRA  = 1'b1
  } pulse_class_t;
endpackage

// File: rtl/fps_us_tick.sv
module fps_us_tick #(
  parameter int DIV = 200
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_every
      assign tick = rst_n;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
      end
      assign tick = (cnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/fps_width_sel.sv
module fps_width_sel
  import fps_pkg::*;
#(
  parameter int LOOP_W       = 10,
  parameter int TW           = 8,
  parameter int SHORT_PASSES = 6,
  parameter int W_SHORT_US   = 30,
  parameter int W_LONG_US    = 200,
  parameter int W_EXTRA_US   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              extra_pulse,
  input  logic [LOOP_W-1:0] loop_cnt,
  output logic [TW-1:0]     width
);
  localparam logic [TW-1:0]     V_SHORT = TW'(W_SHORT_US);
  localparam logic [TW-1:0]     V_LONG  = TW'(W_LONG_US);
  localparam logic [TW-1:0]     V_EXTRA = TW'(W_EXTRA_US);
  localparam logic [LOOP_W-1:0] EARLY   = LOOP_W'(SHORT_PASSES);

  pulse_class_t cls;
  logic [TW-1:0] pick;

  assign cls = pulse_class_t'(extra_pulse);

  always_comb begin
    if (cls == PC_EXTRA)      pick = V_EXTRA;
    else if (loop_cnt <= EARLY) pick = V_SHORT;
    else                      pick = V_LONG;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       width <= V_SHORT;
    else if (capture) width <= pick;
  end
endmodule

// File: rtl/fps_interval.sv
module fps_interval #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          tick,
  output logic          expire
);
  logic [TW-1:0] rem;

  always_ff @(posedge clk) begin
    if (!rst_n)                  rem <= '0;
    else if (load)               rem <= load_val;
    else if (tick && rem != '0)  rem <= rem - 1'b1;
  end

  assign expire = tick && (rem == TW'(1));
endmodule

// File: rtl/flash_pulse_seq.sv
module flash_pulse_seq
  import fps_pkg::*;
#(
  parameter int CLK_PER_US      = 200,
  parameter int T_SETUP_US      = 50,
  parameter int T_HOLD_P_US     = 5,
  parameter int T_HOLD_SETUP_US = 5,
  parameter int W_SHORT_US      = 30,
  parameter int W_LONG_US       = 200,
  parameter int W_EXTRA_US      = 10,
  parameter int SHORT_PASSES    = 6,
  parameter int LOOP_W          = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              extra_pulse,
  input  logic [LOOP_W-1:0] loop_cnt,
  input  logic              abort,
  output logic              wdt_en,
  output logic              psu,
  output logic              prog,
  output logic              done
);
  localparam int M1 = (T_SETUP_US > T_HOLD_P_US) ? T_SETUP_US : T_HOLD_P_US;
  localparam int M2 = (M1 > T_HOLD_SETUP_US) ? M1 : T_HOLD_SETUP_US;
  localparam int M3 = (M2 > W_SHORT_US) ? M2 : W_SHORT_US;
  localparam int M4 = (M3 > W_LONG_US) ? M3 : W_LONG_US;
  localparam int MAX_US = (M4 > W_EXTRA_US) ? M4 : W_EXTRA_US;
  localparam int TW = $clog2(MAX_US + 1);
  localparam logic [TW-1:0] V_SETUP   = TW'(T_SETUP_US);
  localparam logic [TW-1:0] V_RECOVER = TW'(T_HOLD_P_US);
  localparam logic [TW-1:0] V_RELEASE = TW'(T_HOLD_SETUP_US);

  seq_state_t    st, nxt;
  logic          us_tick, expire, ld, accept;
  logic [TW-1:0] ld_val, pulse_w;
  logic          done_q;

  fps_us_tick #(.DIV(CLK_PER_US)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(us_tick)
  );

  fps_width_sel #(
    .LOOP_W(LOOP_W), .TW(TW), .SHORT_PASSES(SHORT_PASSES),
    .W_SHORT_US(W_SHORT_US), .W_LONG_US(W_LONG_US), .W_EXTRA_US(W_EXTRA_US)
  ) u_width (
    .clk(clk), .rst_n(rst_n), .capture(accept),
    .extra_pulse(extra_pulse), .loop_cnt(loop_cnt), .width(pulse_w)
  );

  fps_interval #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val),
    .tick(us_tick), .expire(expire)
  );

  assign accept = (st == ST_IDLE) && start && !abort;

  always_comb begin
    nxt    = st;
    ld     = 1'b0;
    ld_val = '0;
    if (abort) begin
      nxt = ST_IDLE;
    end else begin
      case (st)
        ST_IDLE:    if (start) nxt = ST_ARM;
        ST_ARM: begin
          nxt = ST_SETUP; ld = 1'b1; ld_val = V_SETUP;
        end
        ST_SETUP:   if (expire) begin
          nxt = ST_PULSE; ld = 1'b1; ld_val = pulse_w;
        end
        ST_PULSE:   if (expire) begin
          nxt = ST_RECOVER; ld = 1'b1; ld_val = V_RECOVER;
        end
        ST_RECOVER: if (expire) begin
          nxt = ST_RELEASE; ld = 1'b1; ld_val = V_RELEASE;
        end
        ST_RELEASE: if (expire) nxt = ST_IDLE;
        default:    nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st     <= nxt;
      done_q <= (st == ST_RELEASE) && expire && !abort;
    end
  end

  assign wdt_en = (st != ST_IDLE);
  assign psu    = (st == ST_SETUP) || (st == ST_PULSE) || (st == ST_RECOVER);
  assign prog   = (st == ST_PULSE);
  assign done   = done_q;
endmodule

// File: rtl/fps_checker.sv
module fps_checker #(
  parameter int CLK_PER_US = 200,
  parameter int W_LONG_US  = 200
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic abort,
  input logic wdt_en,
  input logic psu,
  input logic prog,
  input logic done
);
  localparam int P_MAX = CLK_PER_US * W_LONG_US;
  int p_cyc;

  always_ff @(posedge clk) begin
    if (!rst_n)    p_cyc <= 0;
    else if (prog) p_cyc <= p_cyc + 1;
    else           p_cyc <= 0;
  end

  assert_p_inside_psu_R3: assert property (@(posedge clk) disable iff (!rst_n)
    prog |-> psu);

  assert_psu_after_wdt_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(psu) |-> $past(wdt_en));

  assert_start_fresh_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_en) |-> (!psu && !prog && $past(start)));

  assert_psu_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(psu) && !$past(abort)) |-> (!prog && $past(!prog)));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $fell(wdt_en));

  assert_abort_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!wdt_en && !psu && !prog && !done));

  assert_pulse_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    prog |-> (p_cyc < P_MAX));
endmodule

bind flash_pulse_seq fps_checker #(
  .CLK_PER_US(CLK_PER_US),
  .W_LONG_US (W_LONG_US)
) u_fps_checker (
  .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
  .wdt_en(wdt_en), .psu(psu), .prog(prog), .done(done)
);

// File: tb/flash_pulse_seq_bench.sv
module flash_pulse_seq_bench;
  localparam int DIV   = 4;
  localparam int TSU   = 5;
  localparam int TCP   = 3;
  localparam int TCPSU = 8;
  localparam int WS    = 30;
  localparam int WL    = 200;
  localparam int WE    = 10;
  localparam int SP    = 6;
  localparam int LW    = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, extra_pulse = 1'b0, abort = 1'b0;
  logic [LW-1:0] loop_cnt = '0;
  logic wdt_en, psu, prog, done;

  int nchk = 0, nerr = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  flash_pulse_seq #(
    .CLK_PER_US(DIV), .T_SETUP_US(TSU), .T_HOLD_P_US(TCP),
    .T_HOLD_SETUP_US(TCPSU), .W_SHORT_US(WS), .W_LONG_US(WL),
    .W_EXTRA_US(WE), .SHORT_PASSES(SP), .LOOP_W(LW)
  ) u_flash_pulse_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .extra_pulse(extra_pulse),
    .loop_cnt(loop_cnt), .abort(abort), .wdt_en(wdt_en), .psu(psu),
    .prog(prog), .done(done)
  );

  // event monitor, sampled on falling edges
  int cyc = 0;
  logic pw = 0, ps = 0, pp = 0;
  int t_wr, t_sr, t_pr, t_pf, t_sf, t_wf, t_done, n_done, n_wr;

  always @(negedge clk) begin
    cyc++;
    if (wdt_en && !pw) begin n_wr++; if (t_wr < 0) t_wr = cyc; end
    if (psu && !ps && t_sr < 0) t_sr = cyc;
    if (prog && !pp && t_pr < 0) t_pr = cyc;
    if (!prog && pp && t_pf < 0) t_pf = cyc;
    if (!psu && ps && t_sf < 0) t_sf = cyc;
    if (!wdt_en && pw && t_wf < 0) t_wf = cyc;
    if (done) begin n_done++; if (t_done < 0) t_done = cyc; end
    pw = wdt_en; ps = psu; pp = prog;
  end

  task automatic clear_marks();
    t_wr = -1; t_sr = -1; t_pr = -1; t_pf = -1; t_sf = -1; t_wf = -1;
    t_done = -1; n_done = 0; n_wr = 0;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_win(input string tag, input int act, input int us);
    int lo, hi;
    lo = (us - 1) * DIV + 1;
    hi = us * DIV;
    nchk++;
    if (act < lo || act > hi) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d..%0d cycles", tag, act, lo, hi);
    end
  endtask

  task automatic launch(input bit ex, input int lc, output int t0);
    @(posedge clk); #1;
    clear_marks();
    extra_pulse = ex;
    loop_cnt = LW'(lc);
    start = 1'b1;
    t0 = cyc;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_end();
    int n = 0;
    while (t_wf < 0 && n < 6000) begin @(posedge clk); n++; end
    repeat (4) @(posedge clk);
  endtask

  task automatic verify(input int t0, input int wus, input string wtag);
    chk(t_wr == t0 + 2, "R2 wdt_en rise cycle", t_wr, t0 + 2);
    chk(t_sr == t_wr + 1, "R2 psu one cycle after wdt_en", t_sr, t_wr + 1);
    chk(t_pr > t_sr && t_pf > t_pr && t_sf > t_pf && t_wf > t_sf,
        "R2 edge order", t_wf, t_sf + 1);
    chk_win("R8 setup interval", t_pr - t_sr, TSU);
    chk_win(wtag, t_pf - t_pr, wus);
    chk_win("R4 recovery before psu release", t_sf - t_pf, TCP);
    chk_win("R8 release interval", t_wf - t_sf, TCPSU);
    chk(n_done == 1, "R9 done count", n_done, 1);
    chk(t_done == t_wf, "R9 done at wdt_en fall", t_done, t_wf);
  endtask

  task automatic run_seq(input bit ex, input int lc, input int wus, input string wtag);
    int t0;
    launch(ex, lc, t0);
    wait_end();
    verify(t0, wus, wtag);
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(!wdt_en && !psu && !prog && !done, "R1 outputs low after reset",
        {wdt_en, psu, prog, done}, 0);
  endtask

  task automatic test_widths();
    run_seq(1'b0, 1,    WS, "R5 short width loop 1");
    run_seq(1'b0, 6,    WS, "R5 short width loop 6");
    run_seq(1'b0, 0,    WS, "R5 short width loop 0");
    run_seq(1'b0, 7,    WL, "R6 long width loop 7");
    run_seq(1'b0, 1000, WL, "R6 long width loop 1000");
    run_seq(1'b1, 2,    WE, "R7 extra width loop 2");
    run_seq(1'b1, 900,  WE, "R7 extra width loop 900");
  endtask

  task automatic test_busy_start();
    int t0;
    launch(1'b0, 2, t0);
    while (!psu) @(posedge clk);
    #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    while (!prog) @(posedge clk);
    #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    wait_end();
    verify(t0, WS, "R10 width with extra starts");
    repeat (60) @(posedge clk);
    chk(n_wr == 1, "R10 no second sequence", n_wr, 1);
    chk(n_done == 1, "R10 single done", n_done, 1);
  endtask

  task automatic test_sampling();
    int t0;
    launch(1'b0, 3, t0);
    extra_pulse = 1'b1;
    loop_cnt = LW'(500);
    wait_end();
    verify(t0, WS, "R12 width fixed at start");
    extra_pulse = 1'b0;
  endtask

  task automatic test_abort();
    int t0;
    launch(1'b0, 8, t0);
    while (!prog) @(posedge clk);
    #1 abort = 1'b1;
    @(posedge clk); #1 abort = 1'b0;
    @(negedge clk);
    chk(!wdt_en && !psu && !prog, "R11 outputs low after abort",
        {wdt_en, psu, prog}, 0);
    repeat (1200) @(posedge clk);
    chk(n_done == 0, "R11 no done after abort", n_done, 0);
    chk(!wdt_en, "R11 stays idle after abort", wdt_en, 0);
    @(posedge clk); #1;
    clear_marks();
    start = 1'b1; abort = 1'b1;
    @(posedge clk); #1 start = 1'b0; abort = 1'b0;
    repeat (40) @(posedge clk);
    chk(n_wr == 0, "R11 start with abort ignored", n_wr, 0);
    run_seq(1'b0, 4, WS, "R11 normal pulse after abort");
  endtask

  initial begin
    clear_marks();
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    test_reset();
    test_widths();
    test_busy_start();
    test_sampling();
    test_abort();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nerr++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule